// File: doc/BRIEF.md
# Endian-Aware Cache Line Store Merge

This block holds one cache line as a small register array and applies store hits to it. A store carries a word index, the low byte-address bits, an access size (byte, halfword or word), the store data and the current endian mode. The block reads the addressed word, replaces only the byte lanes the store covers, and writes the merged word back. Lane placement follows the endian mode, so the same address bits select mirrored lanes in big-endian mode.

The line is split into two halves, and each half has its own dirty flag. A later write-back needs to copy out only the half that changed. Stores set flags and never clear them. A separate clean input clears both flags, and an invalidate input drops the line's valid bit. A registered read port returns any word of the line. Tag lookup and line fill are handled elsewhere.

Top module: `cache_line_merge`

## Requirements
- R1: A store of size code 2'b10 (word) replaces all 32 bits of the word at `wr_idx` with `wr_data`.
- R2: A store of size code 2'b01 (halfword) writes `wr_data[15:0]` at bit offset 8*((2*big_endian) XOR (2*wr_lo[1])). In little-endian mode, `wr_lo[1]`=1 selects bits 31:16. In big-endian mode, the same bit selects bits 15:0.
- R3: A store of size code 2'b00 (byte) writes `wr_data[7:0]` at bit offset 8*((3*big_endian) XOR `wr_lo`). In little-endian mode, lane 0 is bits 7:0. In big-endian mode, `wr_lo`=0 selects bits 31:24.
- R4: Bits of the addressed word outside the written lanes keep their previous value, and the other words of the line are unchanged.
- R5: A store with size code 2'b11 has no effect on the line words, the dirty flags or the valid bit.
- R6: A store to index 0..WORDS/2-1 sets `dirty_lo` at the next clock edge.
- R7: A store to index WORDS/2..WORDS-1 sets `dirty_hi` at the next clock edge.
- R8: A dirty flag stays set until `clean` is asserted. Stores never clear it.
- R9: `clean` clears both dirty flags at the next edge. A store in the same cycle still sets the flag for its half.
- R10: A store sets `line_valid`. `invalidate` clears it, and it takes priority over a store in the same cycle.
- R11: `rd_data` is registered and shows the word at `rd_idx` as it stood before the current edge. A store at edge k is therefore visible at `rd_data` after edge k+1.
- R12: Synchronous reset clears all words to zero and clears both dirty flags and `line_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Store strobe |
| wr_idx | input | IDX_W | Word index inside the line |
| wr_lo | input | OFS_W | Low byte-address bits of the store |
| wr_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| wr_data | input | DATA_W | Store data, right-aligned |
| big_endian | input | 1 | 1 selects big-endian lane placement |
| clean | input | 1 | Clear both dirty flags |
| invalidate | input | 1 | Clear the valid bit |
| rd_idx | input | IDX_W | Read port word index |
| rd_data | output | DATA_W | Registered read data |
| dirty_lo | output | 1 | Lower half of the line modified |
| dirty_hi | output | 1 | Upper half of the line modified |
| line_valid | output | 1 | Line holds live data |

## Verification
The bench targets the lane mirroring in big-endian mode. A design that used the raw address bits would put big-endian bytes and halfwords in the little-endian lanes, and the read-back word would show the wrong bytes changed. It stores to indices 3 and 4 to check the half boundary, where an off-by-one split would raise the wrong dirty flag. It also drives clean and a store in the same cycle, and invalidate and a store in the same cycle. The reserved size code and a store read back in the same cycle it is written complete the directed set: the first catches a design that still merges or marks dirty, the second one whose read port forwards early.

// File: rtl/clm_pkg.sv
package clm_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } wsize_t;

endpackage

// File: rtl/clm_lane_steer.sv
module clm_lane_steer
  import clm_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [1:0]        size,
  input  logic [OFS_W-1:0]  lo,
  input  logic              big,
  input  logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata,
  output logic              size_ok
);

  logic [OFS_W-1:0] byte_lane;
  logic [OFS_W-1:0] half_lane;

  // Endian mirroring: XOR with the top lane (byte) or top pair (half)
  assign byte_lane = lo ^ (big ? OFS_W'(LANES - 1) : '0);
  assign half_lane = {lo[OFS_W-1:1], 1'b0} ^ (big ? OFS_W'(LANES - 2) : '0);

  always_comb begin
    be      = '0;
    wdata   = '0;
    size_ok = 1'b1;
    case (wsize_t'(size))
      SZ_BYTE: begin
        be    = LANES'(1) << byte_lane;
        wdata = DATA_W'(data[7:0]) << {byte_lane, 3'b000};
      end
      SZ_HALF: begin
        be    = LANES'(2'b11) << half_lane;
        wdata = DATA_W'(data[15:0]) << {half_lane, 3'b000};
      end
      SZ_WORD: begin
        be    = '1;
        wdata = data;
      end
      default: size_ok = 1'b0;
    endcase
  end

  // R3 / R2 / R1: an accepted size enables exactly 1, 2 or all lanes
  always_comb begin
    if (size_ok)
      a_r3_lane_count: assert ($countones(be) == 1 || $countones(be) == 2
                               || $countones(be) == LANES);
  end

endmodule

// File: rtl/clm_line_store.sv
module clm_line_store #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_go,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] old_word;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] bit_mask;

  assign old_word = mem[wr_idx];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bit_mask[l*8 +: 8] = {8{be[l]}};
    assign merged[l*8 +: 8]   = be[l] ? wdata[l*8 +: 8] : old_word[l*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      rd_data <= mem[rd_idx];
      if (wr_go) mem[wr_idx] <= merged;
    end
  end

  // R1-style lane update: enabled lanes carry the store data afterwards
  a_r1_lanes_written: assert property (@(posedge clk) disable iff (rst)
    (!rst && wr_go) |=> ((mem[$past(wr_idx)] & $past(bit_mask))
                         == ($past(wdata) & $past(bit_mask))));

  // R4: lanes outside the store keep their old contents
  a_r4_lanes_kept: assert property (@(posedge clk) disable iff (rst)
    (!rst && wr_go) |=> ((mem[$past(wr_idx)] & ~$past(bit_mask))
                         == ($past(old_word) & ~$past(bit_mask))));

  // R5: without an accepted store the addressed word holds
  a_r5_no_store_hold: assert property (@(posedge clk) disable iff (rst)
    (!rst && !wr_go) |=> (mem[$past(wr_idx)] == $past(old_word)));

endmodule

// File: rtl/clm_flag_track.sv
module clm_flag_track #(
  parameter int WORDS = 8,
  localparam int IDX_W = $clog2(WORDS),
  localparam int HALF  = WORDS / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_go,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             clean,
  input  logic             inval,
  output logic             dirty_lo,
  output logic             dirty_hi,
  output logic             valid
);

  logic in_upper;
  assign in_upper = (wr_idx >= IDX_W'(HALF));

  always_ff @(posedge clk) begin
    if (rst) begin
      dirty_lo <= 1'b0;
      dirty_hi <= 1'b0;
      valid    <= 1'b0;
    end else begin
      dirty_lo <= (dirty_lo & ~clean) | (wr_go & ~in_upper);
      dirty_hi <= (dirty_hi & ~clean) | (wr_go & in_upper);
      valid    <= ~inval & (valid | wr_go);
    end
  end

  a_r6_lower_dirty: assert property (@(posedge clk) disable iff (rst)
    (wr_go && !in_upper) |=> dirty_lo);

  a_r7_upper_dirty: assert property (@(posedge clk) disable iff (rst)
    (wr_go && in_upper) |=> dirty_hi);

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (dirty_lo && dirty_hi && !clean) |=> (dirty_lo && dirty_hi));

  a_r9_clean: assert property (@(posedge clk) disable iff (rst)
    (clean && !wr_go) |=> (!dirty_lo && !dirty_hi));

  a_r10_inval: assert property (@(posedge clk) disable iff (rst)
    inval |=> !valid);

endmodule

// File: rtl/cache_line_merge.sv
module cache_line_merge #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(WORDS),
  localparam int OFS_W = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFS_W-1:0]  wr_lo,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              big_endian,
  input  logic              clean,
  input  logic              invalidate,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              dirty_lo,
  output logic              dirty_hi,
  output logic              line_valid
);

  localparam int LANES = DATA_W / 8;

  logic [LANES-1:0]  be;
  logic [DATA_W-1:0] wdata;
  logic              size_ok;
  logic              wr_go;

  assign wr_go = wr_en & size_ok;

  clm_lane_steer #(.DATA_W(DATA_W)) u_steer (
    .size    (wr_size),
    .lo      (wr_lo),
    .big     (big_endian),
    .data    (wr_data),
    .be      (be),
    .wdata   (wdata),
    .size_ok (size_ok)
  );

  clm_line_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_go   (wr_go),
    .wr_idx  (wr_idx),
    .be      (be),
    .wdata   (wdata),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  clm_flag_track #(.WORDS(WORDS)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .wr_go    (wr_go),
    .wr_idx   (wr_idx),
    .clean    (clean),
    .inval    (invalidate),
    .dirty_lo (dirty_lo),
    .dirty_hi (dirty_hi),
    .valid    (line_valid)
  );

  // R5: the reserved size code never reaches the store path
  a_r5_rsvd_blocked: assert property (@(posedge clk) disable iff (rst)
    (wr_size == 2'b11) |-> !wr_go);

endmodule

// File: tb/cache_line_merge_tb_top.sv
`timescale 1ns/1ps
module cache_line_merge_tb_top;

  localparam int WORDS = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_lo;
  logic [1:0]  wr_size;
  logic [31:0] wr_data;
  logic        big_endian;
  logic        clean;
  logic        invalidate;
  logic [2:0]  rd_idx;
  logic [31:0] rd_data;
  logic        dirty_lo, dirty_hi, line_valid;

  int tests = 0;
  int fails = 0;

  logic [31:0] m [WORDS];
  logic        e_lo, e_hi, e_v;

  always #2.5 clk = ~clk;

  cache_line_merge dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_lo(wr_lo),
    .wr_size(wr_size), .wr_data(wr_data), .big_endian(big_endian),
    .clean(clean), .invalidate(invalidate), .rd_idx(rd_idx),
    .rd_data(rd_data), .dirty_lo(dirty_lo), .dirty_hi(dirty_hi),
    .line_valid(line_valid)
  );

  function automatic logic [31:0] ref_merge(input logic [31:0] old,
      input logic [1:0] sz, input logic [1:0] lo, input logic big,
      input logic [31:0] d);
    logic [31:0] r;
    int lane;
    r = old;
    case (sz)
      2'd0: begin
        lane = big ? (3 - int'(lo)) : int'(lo);
        r[lane*8 +: 8] = d[7:0];
      end
      2'd1: begin
        if (lo >= 2) lane = big ? 0 : 2;
        else         lane = big ? 2 : 0;
        r[lane*8 +: 16] = d[15:0];
      end
      2'd2: r = d;
      default: r = old;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] idx,
      input logic [1:0] lo, input logic [1:0] sz, input logic [31:0] d,
      input logic big, input logic cl, input logic inv,
      input logic [2:0] ridx, input string tag);
    logic [31:0] exp_rd;
    logic go;
    @(negedge clk);
    wr_en = we; wr_idx = idx; wr_lo = lo; wr_size = sz; wr_data = d;
    big_endian = big; clean = cl; invalidate = inv; rd_idx = ridx;
    exp_rd = m[ridx];
    go = we && (sz != 2'b11);
    if (go) m[idx] = ref_merge(m[idx], sz, lo, big, d);
    if (cl) begin e_lo = 1'b0; e_hi = 1'b0; end
    if (go) begin
      if (idx < 4) e_lo = 1'b1;
      else         e_hi = 1'b1;
    end
    if (inv) e_v = 1'b0;
    else if (go) e_v = 1'b1;
    @(posedge clk);
    #1;
    check(tag, "rd_data", rd_data, exp_rd);
    check(tag, "flags {lo,hi,valid}", {29'd0, dirty_lo, dirty_hi, line_valid},
          {29'd0, e_lo, e_hi, e_v});
  endtask

  task automatic wr(input logic [2:0] idx, input logic [1:0] lo,
      input logic [1:0] sz, input logic [31:0] d, input logic big,
      input string tag);
    step(1'b1, idx, lo, sz, d, big, 1'b0, 1'b0, idx, tag);
  endtask

  task automatic rd(input logic [2:0] idx, input string tag);
    step(1'b0, idx, 2'd0, 2'd0, 32'd0, 1'b0, 1'b0, 1'b0, idx, tag);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < WORDS; i++) m[i] = '0;
    e_lo = 0; e_hi = 0; e_v = 0;
    rst = 1; wr_en = 0; wr_idx = 0; wr_lo = 0; wr_size = 0; wr_data = 0;
    big_endian = 0; clean = 0; invalidate = 0; rd_idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R12: reset contents and flags
    for (int i = 0; i < WORDS; i++) rd(3'(i), "R12");

    // R1 / R6 / R10: word store to index 3 (upper edge of lower half)
    wr(3'd3, 2'd0, 2'b10, 32'h11223344, 1'b0, "R1");
    rd(3'd3, "R1_R6_R10");
    // R11: same-cycle read shows old value, next read shows new
    wr(3'd3, 2'd0, 2'b10, 32'hCAFEF00D, 1'b0, "R11");
    rd(3'd3, "R11");
    // R7: index 4 (lower edge of upper half)
    wr(3'd4, 2'd0, 2'b10, 32'h01020304, 1'b0, "R7");
    rd(3'd4, "R7");
    // R2: halfwords both endians
    wr(3'd4, 2'd2, 2'b01, 32'h0000AAAA, 1'b0, "R2");
    rd(3'd4, "R2");
    check("R2", "little half upper", m[4], 32'hAAAA0304);
    wr(3'd4, 2'd2, 2'b01, 32'h0000BBBB, 1'b1, "R2");
    rd(3'd4, "R2");
    check("R2", "big half lower", m[4], 32'hAAAABBBB);
    // R3: bytes both endians
    wr(3'd5, 2'd0, 2'b00, 32'h000000EE, 1'b1, "R3");
    rd(3'd5, "R3");
    check("R3", "big byte0 top lane", m[5], 32'hEE000000);
    wr(3'd5, 2'd1, 2'b00, 32'h00000077, 1'b0, "R3");
    rd(3'd5, "R3_R4");
    // R9: clean alone then clean with store
    step(1'b0, 3'd0, 2'd0, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0, 3'd0, "R9");
    step(1'b1, 3'd6, 2'd3, 2'b00, 32'h55, 1'b0, 1'b1, 1'b0, 3'd6, "R9");
    // R5: reserved size changes nothing
    step(1'b0, 3'd0, 2'd0, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0, 3'd0, "R5");
    wr(3'd1, 2'd0, 2'b11, 32'hFFFFFFFF, 1'b1, "R5");
    rd(3'd1, "R5");
    // R8: flags persist across stores and idle cycles
    wr(3'd0, 2'd0, 2'b10, 32'h12345678, 1'b0, "R8");
    wr(3'd7, 2'd1, 2'b00, 32'h9A, 1'b1, "R8");
    rd(3'd2, "R8");
    // R10: invalidate wins over same-cycle store
    step(1'b1, 3'd2, 2'd0, 2'b10, 32'h0BADBEEF, 1'b0, 1'b0, 1'b1, 3'd2, "R10");
    rd(3'd2, "R10");

    // R4: random mix, whole-line model comparison
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 4) != 0, 3'($urandom), 2'($urandom), 2'($urandom),
           $urandom, 1'($urandom), ($urandom % 16) == 0,
           ($urandom % 32) == 0, 3'($urandom), "R4");
    end

    finish_run();
  end

endmodule